// File: doc/BRIEF.md
# Memory-Capable Lookup Cell

This block is a single storage cell built around a small bank of configuration bits (32 or 64 of them). One set of bits serves four purposes, picked by a two-bit mode input. The cell can act as a combinational lookup function of its read address, as a read-only table, as a small RAM with one write port and one read port, or as a shift register whose depth is chosen at run time. The bank is loaded with its configured pattern whenever the synchronous reset is held. In the two read-only modes that pattern is the only way the contents ever change.

The read port is purely combinational: the read address selects one bit, and the data output follows it in the same cycle. Writes land on the rising clock edge, at a separate write address, and only when write enable is high. In shift mode, write enable acts as the shift enable and the data input enters at bit 0. The read address then picks the tap, so the cell behaves as a delay line whose length can be set anywhere from 1 to DEPTH. The cascade output always carries the highest storage bit. Wiring it to the next cell's data input joins cells into longer shift registers or deeper memories.

Top module: `lutmem_cell`

## Requirements
- R1: While `rst` is high at a rising edge, the bank loads the parameter `INIT` bits [DEPTH-1:0]. After reset, a read at address a returns `INIT[a]`.
- R2: In RAM mode (`mode` = 2'b01), a rising edge with `wr_en` high stores `wr_data` at `wr_addr`. No other bit changes.
- R3: In logic mode (`mode` = 2'b00) and ROM mode (`mode` = 2'b10), edges with `wr_en` high leave every stored bit unchanged.
- R4: In any mode, a rising edge with `wr_en` low leaves every stored bit unchanged.
- R5: In shift mode (`mode` = 2'b11), an edge with `wr_en` high moves bit i to bit i+1 for every i below DEPTH-1 and loads `wr_data` into bit 0. A read at address a then returns the value that entered a+1 enabled shifts earlier.
- R6: `cascade_out` always equals the stored bit at address DEPTH-1. After an enabled shift, it takes the value that bit DEPTH-2 held before the edge.
- R7: `rd_data` is a combinational function of `rd_addr` and the stored bits. A read of the address being written returns the old value until the edge, and the new value after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and shifts happen on its rising edge |
| rst | input | 1 | Synchronous active-high reset; loads the configured pattern |
| mode | input | 2 | 00 logic, 01 RAM, 10 ROM, 11 shift register |
| rd_addr | input | AW | Read address / lookup inputs / shift tap select |
| wr_addr | input | AW | Write address (RAM mode only) |
| wr_data | input | 1 | Write data, or shift-in bit in shift mode |
| wr_en | input | 1 | Write enable, or shift enable in shift mode |
| rd_data | output | 1 | Asynchronous read data |
| cascade_out | output | 1 | Highest storage bit, for chaining cells |

## Verification
The bench writes to the lowest and highest addresses and reads the written address just before the edge. A design that forwarded the write data combinationally would return the new bit early and break the old-value rule. It then tries writes in the two read-only modes. A decoder that only checked the enable would corrupt the configured pattern there, and a full readout of the bank shows that. Long runs in shift mode check the cascade bit and the taps against a model, which catches a shift in the wrong direction or an off-by-one tap. A later reset must bring back the configured pattern after the contents have been overwritten.

// File: rtl/lutmem_pkg.sv
`timescale 1ns/1ps
package lutmem_pkg;

    typedef enum logic [1:0] {
        MODE_LOGIC = 2'b00,
        MODE_RAM   = 2'b01,
        MODE_ROM   = 2'b10,
        MODE_SHIFT = 2'b11
    } cell_mode_e;

    typedef struct packed {
        cell_mode_e mode;
        logic       en;
        logic       data;
    } wr_op_t;

    function automatic logic mode_is_mutable(input cell_mode_e m);
        return (m == MODE_RAM) || (m == MODE_SHIFT);
    endfunction

endpackage

// File: rtl/lutmem_wrctl.sv
`timescale 1ns/1ps
module lutmem_wrctl
    import lutmem_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  wr_op_t           op,
    input  logic [AW-1:0]    addr,
    input  logic [DEPTH-1:0] cur,
    output logic [DEPTH-1:0] nxt
);

    always_comb begin
        nxt = cur;
        if (op.en && mode_is_mutable(op.mode)) begin
            if (op.mode == MODE_SHIFT) begin
                nxt = {cur[DEPTH-2:0], op.data};
            end else begin
                nxt[addr] = op.data;
            end
        end
    end

endmodule

// File: rtl/lutmem_store.sv
`timescale 1ns/1ps
module lutmem_store #(
    parameter int          DEPTH = 32,
    parameter logic [63:0] INIT  = 64'h0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DEPTH-1:0] d,
    output logic [DEPTH-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= INIT[DEPTH-1:0];
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/lutmem_cell.sv
`timescale 1ns/1ps
module lutmem_cell
    import lutmem_pkg::*;
#(
    parameter int          DEPTH = 32,
    parameter logic [63:0] INIT  = 64'h1F3C_A5E0_96D2_4B87,
    localparam int         AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    mode,
    input  logic [AW-1:0] rd_addr,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_data,
    input  logic          wr_en,
    output logic          rd_data,
    output logic          cascade_out
);

    logic [DEPTH-1:0] store_q;
    logic [DEPTH-1:0] store_d;
    wr_op_t           op;

    assign op.mode = cell_mode_e'(mode);
    assign op.en   = wr_en;
    assign op.data = wr_data;

    lutmem_wrctl #(.DEPTH(DEPTH)) u_wrctl (
        .op   (op),
        .addr (wr_addr),
        .cur  (store_q),
        .nxt  (store_d)
    );

    lutmem_store #(.DEPTH(DEPTH), .INIT(INIT)) u_store (
        .clk (clk),
        .rst (rst),
        .d   (store_d),
        .q   (store_q)
    );

    assign rd_data     = store_q[rd_addr];
    assign cascade_out = store_q[DEPTH-1];

endmodule

// File: rtl/lutmem_cell_chk.sv
`timescale 1ns/1ps
module lutmem_cell_chk #(
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       mode,
    input logic [AW-1:0]    wr_addr,
    input logic             wr_data,
    input logic             wr_en,
    input logic             cascade_out,
    input logic [DEPTH-1:0] store_q
);

    p_ram_write_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01 && wr_en) |=> store_q[$past(wr_addr)] == $past(wr_data));

    p_ro_hold_r3: assert property (@(posedge clk) disable iff (rst)
        ((mode == 2'b00 || mode == 2'b10) && wr_en) |=> $stable(store_q));

    p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(store_q));

    p_shift_r5: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b11 && wr_en) |=>
            store_q == {$past(store_q[DEPTH-2:0]), $past(wr_data)});

    p_cascade_r6: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b11 && wr_en) |=> cascade_out == $past(store_q[DEPTH-2]));

endmodule

bind lutmem_cell lutmem_cell_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mode        (mode),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .wr_en       (wr_en),
    .cascade_out (cascade_out),
    .store_q     (store_q)
);

// File: tb/sim_lutmem_cell.sv
`timescale 1ns/1ps
module sim_lutmem_cell;

    localparam int          D    = 32;
    localparam int          AW   = 5;
    localparam logic [63:0] CFG  = 64'h0000_0000_9ABC_5E71;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    mode = 2'b00;
    logic [AW-1:0] rd_addr = '0;
    logic [AW-1:0] wr_addr = '0;
    logic          wr_data = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_data;
    logic          cascade_out;

    int tests = 0;
    int fails = 0;
    logic [D-1:0] model;

    always #2 clk = ~clk;

    lutmem_cell #(.DEPTH(D), .INIT(CFG)) u0 (
        .clk(clk), .rst(rst), .mode(mode), .rd_addr(rd_addr),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en),
        .rd_data(rd_data), .cascade_out(cascade_out)
    );

    function automatic logic [D-1:0] ref_next(input logic [D-1:0] cur,
            input logic [1:0] m, input int wa, input logic wd, input logic we);
        logic [D-1:0] n;
        n = cur;
        if (we && m == 2'b01) n[wa] = wd;
        if (we && m == 2'b11) n = {cur[D-2:0], wd};
        return n;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model = CFG[D-1:0];
    endtask

    task automatic dump(input string req);
        for (int a = 0; a < D; a++) begin
            @(negedge clk);
            wr_en = 1'b0; rd_addr = AW'(a);
            #1 check(req, rd_data, model[a]);
        end
        check({req, " R6 cascade"}, cascade_out, model[D-1]);
    endtask

    // one clocked operation; the read before the edge must show old contents (R7)
    task automatic step(input logic [1:0] m, input int wa, input logic wd,
                        input logic we, input int ra);
        logic [D-1:0] nx;
        @(negedge clk);
        mode = m; wr_addr = AW'(wa); wr_data = wd; wr_en = we; rd_addr = AW'(ra);
        #1 check("R7 pre-edge read", rd_data, model[ra]);
        nx = ref_next(model, m, wa, wd, we);
        @(posedge clk);
        #1 model = nx;
        check("R7 post-edge read", rd_data, model[ra]);
        check("R6 cascade", cascade_out, model[D-1]);
    endtask

    initial begin
        int unsigned sd;
        sd = $urandom(32'd2024);
        do_reset();
        dump("R1 reset contents");

        // R2 / R7: boundary addresses, same-address read around the edge
        step(2'b01, 0, ~model[0], 1'b1, 0);
        step(2'b01, D-1, ~model[D-1], 1'b1, D-1);
        step(2'b01, 13, ~model[13], 1'b1, 13);
        dump("R2 ram write");

        // R3: writes in logic and ROM modes are ignored
        for (int i = 0; i < 8; i++) begin
            step(2'b00, i * 4, ~model[i * 4], 1'b1, i * 4);
            step(2'b10, i * 4 + 1, ~model[i * 4 + 1], 1'b1, i * 4 + 1);
        end
        dump("R3 read-only modes");

        // R4: enable low in every mode
        for (int m = 0; m < 4; m++) step(2'(m), 7, ~model[7], 1'b0, 7);
        dump("R4 enable low");

        // R5 / R6: long shift run, taps checked against model
        for (int i = 0; i < 40; i++) step(2'b11, 0, 1'(i % 3 == 0), 1'b1, (i * 7) % D);
        dump("R5 shift taps");

        // random mix
        for (int i = 0; i < 400; i++)
            step(2'($urandom % 4), int'($urandom % D), 1'($urandom), 1'($urandom),
                 int'($urandom % D));
        dump("R2 R5 random mix");

        // R1: reset restores configured pattern after overwrites
        do_reset();
        dump("R1 reload");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule